// File: doc/BRIEF.md
# Sensor status flag manager

This block keeps the error and status flags that a sensor returns in every serial response frame. Four flags leave it: a power-on indicator, a self-test indicator, a saturation indicator and a frame-error indicator. Each flag has its own set and clear rules.

The power-on indicator comes up out of hardware reset or an undervoltage detect, and a software reset leaves it alone. Software clears it by writing zero to the control register. That clear takes effect only after a fixed 300 ns wait, which is counted in cycles of the system clock.

Saturation is sticky until software acknowledges it by reading the interrupt-status register. The self-test indicator keeps two causes apart. A checksum failure is cleared only by a later passing checksum. A self-test alarm is cleared only by the acknowledging read.

The same control-register write decoder also drives the power-down level and the start pulses for self-diagnosis and the memory test. The serial receiver supplies single-cycle pulses for frame errors, good frames, decoded control writes and decoded status reads. Every flag is registered, so each output changes on the clock edge that samples its cause.

Top module: `stat_flag_mgr`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, porst_o is 1 and st_o, sat_o, frme_o, pdown_o, diag_start_o and memtest_start_o are all 0.
- R2: A clock edge that samples uv_det_i high leaves porst_o at 1 after that edge. sw_rst_i never sets porst_o and never clears it.
- R3: Suppose a control write (ctrl_wr_i high) carries data 0x00 while porst_o is 1. Then porst_o falls on exactly the D-th clock edge after the write edge, where D = ceil(300 ns × CLK_HZ) and D is at least 1. Any other data value starts no clear.
- R4: sat_o goes to 1 after any edge that samples a nonzero sat_axis_i. It then holds 1, even after saturation ends, until an edge that samples int_stat_rd_i or sw_rst_i.
- R5: cksum_fail_i sets st_o. That cause is removed only by cksum_pass_i or sw_rst_i. int_stat_rd_i does not remove it.
- R6: stc_alarm_i or sts_alarm_i sets st_o. That cause is removed only by int_stat_rd_i or sw_rst_i. cksum_pass_i does not remove it. st_o is 1 while either cause is held.
- R7: frm_err_i sets frme_o and frm_ok_i clears it.
- R8: When a set event and a clear event for the same flag are sampled on the same edge, the flag ends up 1. This covers undervoltage together with a pending or newly written PORST clear.
- R9: sw_rst_i clears sat_o, both self-test causes, frme_o and pdown_o on the next edge. porst_o is left unchanged.
- R10: A control write of 0x20 sets pdown_o, which stays set until sw_rst_i. A write of 0x08 makes diag_start_o 1 for the one cycle after the write edge. A write of 0x04 does the same for memtest_start_o. Every data value other than 0x00, 0x04, 0x08 and 0x20 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous hardware (power-on) reset |
| uv_det_i | input | 1 | Undervoltage detected |
| sw_rst_i | input | 1 | Software reset pulse |
| sat_axis_i | input | NUM_AXES | Per-axis saturation |
| stc_alarm_i | input | 1 | Self-test alarm, first source |
| sts_alarm_i | input | 1 | Self-test alarm, second source |
| cksum_pass_i | input | 1 | Checksum calculation passed (pulse) |
| cksum_fail_i | input | 1 | Checksum calculation failed (pulse) |
| frm_err_i | input | 1 | Invalid frame received (pulse) |
| frm_ok_i | input | 1 | Valid frame received (pulse) |
| ctrl_wr_i | input | 1 | Decoded control-register write strobe |
| ctrl_wdata_i | input | 8 | Control-register write data |
| int_stat_rd_i | input | 1 | Decoded interrupt-status read strobe |
| porst_o | output | 1 | Power-on / undervoltage indicator |
| st_o | output | 1 | Self-test indicator |
| sat_o | output | 1 | Saturation indicator |
| frme_o | output | 1 | Frame-error indicator |
| pdown_o | output | 1 | Power-down request level |
| diag_start_o | output | 1 | Self-diagnosis start pulse |
| memtest_start_o | output | 1 | Memory self-test start pulse |

## Verification
The bench builds two copies with NUM_AXES = 3.

The main copy runs at CLK_HZ = 125 MHz. There the clear delay rounds up from 37.5 to 38 cycles.

The second copy runs at 10 MHz. There the delay is exactly 3 cycles, which exposes an off-by-one in the counter load or in the rounding.

Three axes make all eight saturation patterns cheap to sweep. The 8-bit control data lets every one of the 256 write values be checked against the decoded actions, and against the power-on clear that must not start.

// File: rtl/flag_mgr_pkg.sv
package flag_mgr_pkg;

  localparam int unsigned CTRL_W = 8;
  typedef logic [CTRL_W-1:0] ctrl_byte_t;

  localparam ctrl_byte_t CMD_PORST_CLR = 8'h00;
  localparam ctrl_byte_t CMD_PDOWN     = 8'h20;
  localparam ctrl_byte_t CMD_DIAG      = 8'h08;
  localparam ctrl_byte_t CMD_MEMTEST   = 8'h04;

  // sticky flag slots
  localparam int unsigned F_SAT    = 0;
  localparam int unsigned F_CKS    = 1;
  localparam int unsigned F_ALM    = 2;
  localparam int unsigned F_FRME   = 3;
  localparam int unsigned N_STICKY = 4;

  function automatic int unsigned dly_cycles(longint unsigned clk_hz, int unsigned ns);
    longint unsigned c;
    c = (clk_hz * 64'(ns) + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 64'd1) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);

  p_clr_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/porst_ctrl.sv
module porst_ctrl #(
  parameter longint unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned     CLR_DLY_NS = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_det_i,
  input  logic clr_req_i,
  output logic porst_o
);

  localparam int unsigned DlyCyc = flag_mgr_pkg::dly_cycles(CLK_HZ, CLR_DLY_NS);
  localparam int unsigned CntW   = $clog2(DlyCyc + 1);

  logic            porst_q;
  logic            pend_q;
  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      porst_q <= 1'b1;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (uv_det_i) begin
      // set beats any clear, pending or new
      porst_q <= 1'b1;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (clr_req_i && porst_q) begin
      pend_q  <= 1'b1;
      cnt_q   <= CntW'(DlyCyc);
    end else if (pend_q) begin
      if (cnt_q == CntW'(1)) begin
        porst_q <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign porst_o = porst_q;

  p_porst_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(porst_q) |-> $past(uv_det_i));

  p_porst_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(porst_q) |-> $past(pend_q));

  p_uv_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_det_i |=> (porst_q && !pend_q));

endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import flag_mgr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  ctrl_byte_t data_i,
  input  logic       sw_rst_i,
  output logic       porst_clr_o,
  output logic       pdown_o,
  output logic       diag_o,
  output logic       mem_o
);

  logic pdown_set;

  assign porst_clr_o = wr_i && (data_i == CMD_PORST_CLR);
  assign pdown_set   = wr_i && (data_i == CMD_PDOWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdown_o <= 1'b0;
      diag_o  <= 1'b0;
      mem_o   <= 1'b0;
    end else begin
      diag_o <= wr_i && (data_i == CMD_DIAG);
      mem_o  <= wr_i && (data_i == CMD_MEMTEST);
      if (pdown_set)     pdown_o <= 1'b1;
      else if (sw_rst_i) pdown_o <= 1'b0;
    end
  end

  p_diag_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(diag_o) |-> $past(wr_i));

  p_pulse_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({diag_o, mem_o}));

  p_pdown_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdown_o && !sw_rst_i) |=> pdown_o);

endmodule

// File: rtl/stat_flag_mgr.sv
module stat_flag_mgr
  import flag_mgr_pkg::*;
#(
  parameter int unsigned     NUM_AXES   = 3,
  parameter longint unsigned CLK_HZ     = 125_000_000,
  parameter int unsigned     CLR_DLY_NS = 300
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                uv_det_i,
  input  logic                sw_rst_i,
  input  logic [NUM_AXES-1:0] sat_axis_i,
  input  logic                stc_alarm_i,
  input  logic                sts_alarm_i,
  input  logic                cksum_pass_i,
  input  logic                cksum_fail_i,
  input  logic                frm_err_i,
  input  logic                frm_ok_i,
  input  logic                ctrl_wr_i,
  input  logic [7:0]          ctrl_wdata_i,
  input  logic                int_stat_rd_i,
  output logic                porst_o,
  output logic                st_o,
  output logic                sat_o,
  output logic                frme_o,
  output logic                pdown_o,
  output logic                diag_start_o,
  output logic                memtest_start_o
);

  logic [N_STICKY-1:0] set_v, clr_v, q_v;
  logic                porst_clr;

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[F_SAT]  = |sat_axis_i;
    clr_v[F_SAT]  = int_stat_rd_i | sw_rst_i;
    set_v[F_CKS]  = cksum_fail_i;
    clr_v[F_CKS]  = cksum_pass_i | sw_rst_i;
    set_v[F_ALM]  = stc_alarm_i | sts_alarm_i;
    clr_v[F_ALM]  = int_stat_rd_i | sw_rst_i;
    set_v[F_FRME] = frm_err_i;
    clr_v[F_FRME] = frm_ok_i | sw_rst_i;
  end

  for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
    sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .q_o    (q_v[i])
    );
  end

  ctrl_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_wr_i),
    .data_i      (ctrl_wdata_i),
    .sw_rst_i    (sw_rst_i),
    .porst_clr_o (porst_clr),
    .pdown_o     (pdown_o),
    .diag_o      (diag_start_o),
    .mem_o       (memtest_start_o)
  );

  porst_ctrl #(
    .CLK_HZ     (CLK_HZ),
    .CLR_DLY_NS (CLR_DLY_NS)
  ) u_porst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uv_det_i  (uv_det_i),
    .clr_req_i (porst_clr),
    .porst_o   (porst_o)
  );

  assign sat_o  = q_v[F_SAT];
  assign st_o   = q_v[F_CKS] | q_v[F_ALM];
  assign frme_o = q_v[F_FRME];

  p_sat_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sat_axis_i) |=> sat_o);

  p_sat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !int_stat_rd_i && !sw_rst_i) |=> sat_o);

  p_st_cks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cksum_fail_i |=> st_o);

  p_st_alm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stc_alarm_i || sts_alarm_i) |=> st_o);

  p_st_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(st_o) |-> $past(cksum_pass_i || int_stat_rd_i || sw_rst_i));

  p_frme_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_i |=> frme_o);

  p_sw_keep_porst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_i && !uv_det_i && !porst_clr) |=> $stable(porst_o));

endmodule

// File: tb/tb_stat_flag_mgr.sv
module tb_stat_flag_mgr;

  localparam longint unsigned HZ_HI = 125_000_000;
  localparam longint unsigned HZ_LO = 10_000_000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       uv_det_i = 1'b0, sw_rst_i = 1'b0;
  logic [2:0] sat_axis_i = '0;
  logic       stc_alarm_i = 1'b0, sts_alarm_i = 1'b0;
  logic       cksum_pass_i = 1'b0, cksum_fail_i = 1'b0;
  logic       frm_err_i = 1'b0, frm_ok_i = 1'b0;
  logic       ctrl_wr_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic       int_stat_rd_i = 1'b0;

  logic porst_o, st_o, sat_o, frme_o, pdown_o, diag_start_o, memtest_start_o;
  logic porst_lo, st_lo, sat_lo, frme_lo, pdown_lo, diag_lo, mem_lo;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  stat_flag_mgr #(.NUM_AXES(3), .CLK_HZ(HZ_HI)) dut (
    .clk_i, .rst_ni, .uv_det_i, .sw_rst_i, .sat_axis_i, .stc_alarm_i, .sts_alarm_i,
    .cksum_pass_i, .cksum_fail_i, .frm_err_i, .frm_ok_i, .ctrl_wr_i, .ctrl_wdata_i,
    .int_stat_rd_i, .porst_o, .st_o, .sat_o, .frme_o, .pdown_o, .diag_start_o,
    .memtest_start_o);

  stat_flag_mgr #(.NUM_AXES(3), .CLK_HZ(HZ_LO)) dut_lo (
    .clk_i, .rst_ni, .uv_det_i, .sw_rst_i, .sat_axis_i, .stc_alarm_i, .sts_alarm_i,
    .cksum_pass_i, .cksum_fail_i, .frm_err_i, .frm_ok_i, .ctrl_wr_i, .ctrl_wdata_i,
    .int_stat_rd_i, .porst_o(porst_lo), .st_o(st_lo), .sat_o(sat_lo), .frme_o(frme_lo),
    .pdown_o(pdown_lo), .diag_start_o(diag_lo), .memtest_start_o(mem_lo));

  function automatic int exp_dly(longint unsigned hz);
    longint unsigned c;
    c = (hz * 64'd300 + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    uv_det_i = 0; sw_rst_i = 0; sat_axis_i = '0; stc_alarm_i = 0; sts_alarm_i = 0;
    cksum_pass_i = 0; cksum_fail_i = 0; frm_err_i = 0; frm_ok_i = 0;
    ctrl_wr_i = 0; ctrl_wdata_i = '0; int_stat_rd_i = 0;
  endtask

  task automatic step();
    tick();
    idle();
  endtask

  task automatic wr(input logic [7:0] v);
    ctrl_wr_i = 1; ctrl_wdata_i = v;
    step();
  endtask

  task automatic chk_flags(input string req, input int p, input int s, input int a, input int f);
    chk({req, " porst"}, porst_o, p);
    chk({req, " st"},    st_o,    s);
    chk({req, " sat"},   sat_o,   a);
    chk({req, " frme"},  frme_o,  f);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int d_hi, d_lo, z_hi, z_lo;
    d_hi = exp_dly(HZ_HI);
    d_lo = exp_dly(HZ_LO);
    chk("R3 delay formula hi", d_hi, 38);
    chk("R3 delay formula lo", d_lo, 3);

    // R1 reset values
    repeat (3) tick();
    chk_flags("R1 in reset", 1, 0, 0, 0);
    chk("R1 pdown", pdown_o, 0);
    chk("R1 porst lo", porst_lo, 1);
    rst_ni = 1;
    tick();
    chk_flags("R1 after release", 1, 0, 0, 0);
    chk("R1 pulses", {pdown_o, diag_start_o, memtest_start_o}, 0);

    // R2 sw reset keeps porst at 1
    sw_rst_i = 1; step();
    chk("R2 sw_rst keeps porst", porst_o, 1);

    // R3 exact delay on both builds
    wr(8'h00);
    z_hi = -1; z_lo = -1;
    for (int k = 1; k <= 45; k++) begin
      tick();
      if (porst_o == 0 && z_hi < 0) z_hi = k;
      if (porst_lo == 0 && z_lo < 0) z_lo = k;
    end
    chk("R3 clear edge hi", z_hi, d_hi);
    chk("R3 clear edge lo", z_lo, d_lo);

    // R2 sw reset never sets porst
    sw_rst_i = 1; step();
    chk("R2 sw_rst no set", porst_o, 0);
    // R2 undervoltage sets
    uv_det_i = 1; step();
    chk("R2 uv sets hi", porst_o, 1);
    chk("R2 uv sets lo", porst_lo, 1);

    // R8 uv during pending clear cancels it
    wr(8'h00);
    repeat (4) tick();
    uv_det_i = 1; step();
    repeat (45) tick();
    chk("R8 uv cancels clear hi", porst_o, 1);
    chk("R8 uv cancels clear lo", porst_lo, 1);

    // R8 uv and clear write on the same edge
    uv_det_i = 1; ctrl_wr_i = 1; ctrl_wdata_i = 8'h00; step();
    repeat (45) tick();
    chk("R8 uv with write hi", porst_o, 1);
    chk("R8 uv with write lo", porst_lo, 1);

    // R10 sweep over all write values other than 0x00
    for (int v = 1; v < 256; v++) begin
      ctrl_wr_i = 1; ctrl_wdata_i = 8'(v);
      step();
      chk("R10 diag pulse", diag_start_o, (v == 8) ? 1 : 0);
      chk("R10 memtest pulse", memtest_start_o, (v == 4) ? 1 : 0);
      chk("R10 pdown", pdown_o, (v == 32) ? 1 : 0);
      tick();
      chk("R10 pulse width", {diag_start_o, memtest_start_o}, 0);
      chk("R10 pdown held", pdown_o, (v == 32) ? 1 : 0);
      repeat (3) tick();
      chk("R3 no clear on other value", {porst_o, porst_lo}, 3);
      chk("R10 no flag effect", {st_o, sat_o, frme_o}, 0);
      sw_rst_i = 1; step();
      chk("R9 pdown cleared", pdown_o, 0);
    end

    // R4 all saturation patterns
    for (int p = 0; p < 8; p++) begin
      sat_axis_i = 3'(p); step();
      chk("R4 sat set", sat_o, (p != 0) ? 1 : 0);
      repeat (2) tick();
      chk("R4 sat sticky", sat_o, (p != 0) ? 1 : 0);
      int_stat_rd_i = 1; step();
      chk("R4 sat ack", sat_o, 0);
    end
    sat_axis_i = 3'b010; int_stat_rd_i = 1; step();
    chk("R8 sat set wins", sat_o, 1);
    int_stat_rd_i = 1; step();
    chk("R4 sat ack", sat_o, 0);

    // R5 checksum cause
    cksum_fail_i = 1; step();
    chk("R5 fail sets st", st_o, 1);
    int_stat_rd_i = 1; step();
    chk("R5 read keeps st", st_o, 1);
    cksum_pass_i = 1; step();
    chk("R5 pass clears st", st_o, 0);
    cksum_fail_i = 1; cksum_pass_i = 1; step();
    chk("R8 fail beats pass", st_o, 1);
    cksum_pass_i = 1; step();
    chk("R5 pass clears st", st_o, 0);

    // R6 alarm causes
    stc_alarm_i = 1; step();
    chk("R6 stc sets st", st_o, 1);
    cksum_pass_i = 1; step();
    chk("R6 pass keeps st", st_o, 1);
    int_stat_rd_i = 1; step();
    chk("R6 read clears st", st_o, 0);
    sts_alarm_i = 1; step();
    chk("R6 sts sets st", st_o, 1);
    sts_alarm_i = 1; int_stat_rd_i = 1; step();
    chk("R8 alarm beats read", st_o, 1);
    int_stat_rd_i = 1; step();
    chk("R6 read clears st", st_o, 0);
    cksum_fail_i = 1; stc_alarm_i = 1; step();
    int_stat_rd_i = 1; step();
    chk("R6 both causes read", st_o, 1);
    cksum_pass_i = 1; step();
    chk("R6 both causes pass", st_o, 0);

    // R7 frame error
    frm_err_i = 1; step();
    chk("R7 frme set", frme_o, 1);
    repeat (2) tick();
    chk("R7 frme held", frme_o, 1);
    frm_ok_i = 1; step();
    chk("R7 frme clear", frme_o, 0);
    frm_err_i = 1; frm_ok_i = 1; step();
    chk("R8 frme set wins", frme_o, 1);
    frm_ok_i = 1; step();
    chk("R7 frme clear", frme_o, 0);

    // R9 software reset clears all but porst
    sat_axis_i = 3'b100; cksum_fail_i = 1; stc_alarm_i = 1; frm_err_i = 1; step();
    wr(8'h20);
    chk_flags("R9 before sw_rst", 1, 1, 1, 1);
    chk("R9 pdown before", pdown_o, 1);
    sw_rst_i = 1; step();
    chk_flags("R9 after sw_rst", 1, 0, 0, 0);
    chk("R9 pdown after", pdown_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule